// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block carries out the seven data-movement operations of a small 16-bit machine: load direct, load indirect, load base-relative, load effective address, store direct, store indirect and store base-relative. Memory is word addressed, with 2^16 locations of 16 bits each. The block takes one instruction word, the incremented program counter and two register-file read values: a base value and a store-source value. From these it forms an effective address and runs one or two transactions on a simple synchronous memory port. Loads and address computations then write one result to the destination register and update a three-bit sign flag register.

A controller offers an operation by raising `op_valid` while `busy` is low. The unit accepts it on that clock edge and latches every operand. It then works through a small state machine. The states are:

- `ST_IDLE`: waiting for an operation.
- `ST_PTR`: indirect pointer read.
- `ST_DATA`: the data read or write.
- `ST_WB`: register write-back.

The transitions are:

- IDLE→DATA: direct and base-relative operations.
- IDLE→PTR: indirect operations.
- IDLE→WB: address-only operation.
- PTR→DATA: when the pointer read completes.
- DATA→WB: when a load completes.
- DATA→IDLE: when a store completes.
- WB→IDLE: always.

Memory requests wait in place until the memory raises `mem_ready`.

Top module: `ldst_unit`

## Requirements
- R1: After reset `busy`, `mem_valid`, `mem_we` and `rf_we` are low, and `cc_nzp` reads 3'b010.
- R2: The operation code sits in word bits [15:12]. The accepted codes are 0010 load direct, 0011 store direct, 0110 load base-relative, 0111 store base-relative, 1010 load indirect, 1011 store indirect and 1110 load effective address. Any other code is ignored: it causes no request, no register write and no `busy`.
- R3: Direct, indirect and effective-address operations compute `op_pc_inc` plus word bits [8:0] sign-extended to 16 bits. The sum wraps modulo 2^16.
- R4: Base-relative operations compute `op_base` plus word bits [5:0] sign-extended to 16 bits. The sum wraps modulo 2^16.
- R5: A direct or base-relative load makes exactly one read at the computed address. It then raises `rf_we` for one cycle, with `rf_dst` equal to word bits [11:9] and `rf_wdata` equal to the word read.
- R6: A store writes `op_src` (as latched at acceptance) in one write transaction. It makes no register write and leaves `cc_nzp` unchanged.
- R7: An indirect operation first reads a pointer at the computed address. It then makes its read or write at that pointer, as a second transaction.
- R8: The effective-address operation makes no memory transaction and writes the computed address to the destination register.
- R9: After each register write `cc_nzp` holds exactly one set bit, with [2]=negative, [1]=zero and [0]=positive, taken from the value written. The new value is visible from the cycle after the `rf_we` cycle.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R11: `busy` rises in the cycle after acceptance. It stays high for 2 cycles (direct/base load), 3 (indirect load), 1 (direct/base store), 2 (indirect store) or 1 (effective address), plus one cycle for each memory wait cycle. `op_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_word | input | 16 | Instruction word |
| op_pc_inc | input | 16 | Incremented program counter |
| op_base | input | 16 | Base register value |
| op_src | input | 16 | Store source register value |
| busy | output | 1 | Operation in progress; new offers refused |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| rf_we | output | 1 | Destination register write strobe |
| rf_dst | output | 3 | Destination register index |
| rf_wdata | output | 16 | Destination register value |
| cc_nzp | output | 3 | Sign flags {N,Z,P} |

## Verification
Acceptance happens at the edge where `op_valid` is sampled. From then on each cycle corresponds to exactly one state, so every result has a fixed due time:

- The first request appears one cycle after acceptance.
- A zero-wait load writes the register two cycles after acceptance.
- The flags change one cycle after that write.

The bench drives inputs and samples outputs on falling edges. It records transactions and register writes as they complete on rising edges. It checks `busy` by counting falling edges, which catches any extra or missing state. The memory model inserts a programmable number of wait cycles, so that the hold rule and the wait-cycle arithmetic are exercised.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int WORD_W   = 16;
    localparam int RIDX_W   = 3;
    localparam int OPC_W    = 4;
    localparam int PCOFF_W  = 9;
    localparam int BOFF_W   = 6;
    localparam int NZP_W    = 3;

    localparam logic [OPC_W-1:0] OPC_LD  = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ST  = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_LDI = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_STI = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_LEA = 4'b1110;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2,
        ST_WB   = 2'd3
    } state_e;

    typedef struct packed {
        logic legal;
        logic is_store;
        logic indirect;
        logic addr_only;
        logic base_mode;
    } op_class_t;

    function automatic op_class_t classify(input logic [OPC_W-1:0] opc);
        op_class_t c;
        c = '0;
        unique case (opc)
            OPC_LD:  begin c.legal = 1'b1; end
            OPC_ST:  begin c.legal = 1'b1; c.is_store = 1'b1; end
            OPC_LDR: begin c.legal = 1'b1; c.base_mode = 1'b1; end
            OPC_STR: begin c.legal = 1'b1; c.base_mode = 1'b1; c.is_store = 1'b1; end
            OPC_LDI: begin c.legal = 1'b1; c.indirect = 1'b1; end
            OPC_STI: begin c.legal = 1'b1; c.indirect = 1'b1; c.is_store = 1'b1; end
            OPC_LEA: begin c.legal = 1'b1; c.addr_only = 1'b1; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ldst_sext.sv
module ldst_sext #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign dout = {{PAD_W{din[IN_W-1]}}, din};
        end else begin : g_trunc
            assign dout = din[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu #(
    parameter int W       = 16,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic [W-1:0] word,
    input  logic [W-1:0] pc_inc,
    input  logic [W-1:0] base_val,
    input  logic         base_mode,
    output logic [W-1:0] ea
);
    logic [W-1:0] pc_off;
    logic [W-1:0] base_off;

    ldst_sext #(.IN_W(PCOFF_W), .OUT_W(W)) u_sext_pc (
        .din  (word[PCOFF_W-1:0]),
        .dout (pc_off)
    );

    ldst_sext #(.IN_W(BOFF_W), .OUT_W(W)) u_sext_base (
        .din  (word[BOFF_W-1:0]),
        .dout (base_off)
    );

    // Modulo-2^W sums: the carry out is simply dropped.
    always_comb begin
        if (base_mode) ea = base_val + base_off;
        else           ea = pc_inc + pc_off;
    end
endmodule

// File: rtl/ldst_nzp.sv
module ldst_nzp #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic [2:0]   nzp
);
    logic is_zero;
    assign is_zero = (val == '0);
    assign nzp = {val[W-1], is_zero, ~val[W-1] & ~is_zero};
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [WORD_W-1:0]   op_word,
    input  logic [WORD_W-1:0]   op_pc_inc,
    input  logic [WORD_W-1:0]   op_base,
    input  logic [WORD_W-1:0]   op_src,
    output logic                busy,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                rf_we,
    output logic [RIDX_W-1:0]   rf_dst,
    output logic [WORD_W-1:0]   rf_wdata,
    output logic [NZP_W-1:0]    cc_nzp
);
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int DST_LSB = OPC_LSB - RIDX_W;
    localparam logic [NZP_W-1:0] CC_RESET = 3'b010;

    state_e       state_q, state_d;
    op_class_t    cls;
    logic         accept;
    logic [WORD_W-1:0] ea;
    logic [WORD_W-1:0] addr_q, src_q, res_q;
    logic [RIDX_W-1:0] dst_q;
    logic              store_q;
    logic [NZP_W-1:0]  cc_q, cc_next;

    assign cls    = classify(op_word[WORD_W-1:OPC_LSB]);
    assign accept = op_valid && (state_q == ST_IDLE) && cls.legal;

    ldst_agu #(.W(WORD_W), .PCOFF_W(PCOFF_W), .BOFF_W(BOFF_W)) u_agu (
        .word      (op_word),
        .pc_inc    (op_pc_inc),
        .base_val  (op_base),
        .base_mode (cls.base_mode),
        .ea        (ea)
    );

    ldst_nzp #(.W(WORD_W)) u_nzp (
        .val (res_q),
        .nzp (cc_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cls.addr_only)     state_d = ST_WB;
                    else if (cls.indirect) state_d = ST_PTR;
                    else                   state_d = ST_DATA;
                end
            end
            ST_PTR:  if (mem_ready) state_d = ST_DATA;
            ST_DATA: if (mem_ready) state_d = store_q ? ST_IDLE : ST_WB;
            ST_WB:   state_d = ST_IDLE;
        endcase
    end

    // Operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            src_q   <= '0;
            res_q   <= '0;
            dst_q   <= '0;
            store_q <= 1'b0;
            cc_q    <= CC_RESET;
        end else begin
            if (accept) begin
                addr_q  <= ea;
                res_q   <= ea;
                src_q   <= op_src;
                dst_q   <= op_word[DST_LSB +: RIDX_W];
                store_q <= cls.is_store;
            end
            if (state_q == ST_PTR && mem_ready)
                addr_q <= mem_rdata;
            if (state_q == ST_DATA && mem_ready && !store_q)
                res_q <= mem_rdata;
            if (state_q == ST_WB)
                cc_q <= cc_next;
        end
    end

    // Output decode
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        rf_we     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PTR:  mem_valid = 1'b1;
            ST_DATA: begin
                mem_valid = 1'b1;
                mem_we    = store_q;
                mem_wdata = src_q;
            end
            ST_WB:   rf_we = 1'b1;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign mem_addr = addr_q;
    assign rf_dst   = dst_q;
    assign rf_wdata = res_q;
    assign cc_nzp   = cc_q;

    // Assertions
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we); // R5
    AST_WB_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !mem_valid); // R8
    AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cc_nzp) == 1); // R9
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rf_we)) |-> $stable(cc_nzp)); // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_valid)); // R11
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy); // R11
endmodule

// File: tb/tb_ldst_unit.sv
`timescale 1ns/1ps
module tb_ldst_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0, op_pc_inc = '0, op_base = '0, op_src = '0;
    logic        busy, mem_valid, mem_ready, mem_we, rf_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, rf_wdata;
    logic [2:0]  rf_dst, cc_nzp;

    always #4 clk = ~clk;

    ldst_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .op_pc_inc(op_pc_inc), .op_base(op_base), .op_src(op_src),
        .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_dst(rf_dst),
        .rf_wdata(rf_wdata), .cc_nzp(cc_nzp)
    );

    // Behavioural memory: 256 words aliased on the low address byte.
    logic [15:0] mem [256];
    int          wait_n = 0;
    int          wcnt = 0;
    assign mem_ready = mem_valid && (wcnt == wait_n);
    assign mem_rdata = mem[mem_addr[7:0]];

    // Logs of completed transactions and register writes
    int          acc_n = 0, wr_n = 0;
    logic [15:0] acc_addr [16];
    logic        acc_we   [16];
    logic [15:0] wr_data  [16];
    logic [2:0]  wr_dst   [16];

    always @(posedge clk) begin
        if (mem_valid && !mem_ready) wcnt <= wcnt + 1;
        else                         wcnt <= 0;
        if (mem_valid && mem_ready) begin
            acc_addr[acc_n % 16] <= mem_addr;
            acc_we[acc_n % 16]   <= mem_we;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            acc_n <= acc_n + 1;
        end
        if (rf_we) begin
            wr_data[wr_n % 16] <= rf_wdata;
            wr_dst[wr_n % 16]  <= rf_dst;
            wr_n <= wr_n + 1;
        end
    end

    int tests = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pcw(input logic [3:0] opc, input logic [2:0] r, input logic [8:0] off);
        return {opc, r, off};
    endfunction

    function automatic logic [15:0] bsw(input logic [3:0] opc, input logic [2:0] r, input logic [5:0] off);
        return {opc, r, 3'd5, off};
    endfunction

    int a0, w0, bcyc;

    // Offer one operation; optionally offer an intruder in the first busy cycle.
    task automatic run_op(input logic [15:0] w, input logic [15:0] pc, input logic [15:0] b,
                          input logic [15:0] s, input int waits, input bit intrude);
        wait_n = waits;
        a0 = acc_n; w0 = wr_n;
        @(negedge clk);
        op_word = w; op_pc_inc = pc; op_base = b; op_src = s; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (intrude) begin
            op_word = pcw(4'b0011, 3'd1, 9'h000); op_pc_inc = 16'h00C0; op_src = 16'hDEAD;
        end else op_valid = 1'b0;
        bcyc = 0;
        while (busy && bcyc < 200) begin
            bcyc++;
            @(negedge clk);
            op_valid = 1'b0;
        end
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "mem_valid", mem_valid, 0);
        chk("R1", "rf_we", rf_we, 0);
        chk("R1", "cc_nzp", cc_nzp, 3'b010);
    endtask

    task automatic t_ld_direct();
        mem[8'h35] = 16'h1234;
        run_op(pcw(4'b0010, 3'd3, 9'd5), 16'h0030, 16'h0, 16'h0, 0, 0);
        chk("R3", "ld addr", acc_addr[a0 % 16], 16'h0035);
        chk("R5", "ld acc count", acc_n - a0, 1);
        chk("R5", "ld dst", wr_dst[w0 % 16], 3'd3);
        chk("R5", "ld data", wr_data[w0 % 16], 16'h1234);
        chk("R9", "ld flags P", cc_nzp, 3'b001);
        chk("R11", "ld busy cycles", bcyc, 2);
    endtask

    task automatic t_ld_wrap();
        mem[8'hFF] = 16'h8001;
        run_op(pcw(4'b0010, 3'd6, 9'h1FD), 16'h0002, 16'h0, 16'h0, 0, 0);
        chk("R3", "wrap addr", acc_addr[a0 % 16], 16'hFFFF);
        chk("R9", "wrap flags N", cc_nzp, 3'b100);
    endtask

    task automatic t_ldr_wait();
        mem[8'h20] = 16'h0000;
        run_op(bsw(4'b0110, 3'd2, 6'h20), 16'h0000, 16'h1040, 16'h0, 2, 0);
        chk("R4", "ldr addr", acc_addr[a0 % 16], 16'h1020);
        chk("R5", "ldr data", wr_data[w0 % 16], 16'h0000);
        chk("R9", "ldr flags Z", cc_nzp, 3'b010);
        chk("R10", "ldr busy with waits", bcyc, 4);
    endtask

    task automatic t_str();
        logic [2:0] cc0;
        cc0 = cc_nzp;
        run_op(bsw(4'b0111, 3'd4, 6'h1F), 16'h0000, 16'h2000, 16'hBEEF, 0, 0);
        chk("R4", "str addr", acc_addr[a0 % 16], 16'h201F);
        chk("R6", "str we", acc_we[a0 % 16], 1);
        chk("R6", "str data", mem[8'h1F], 16'hBEEF);
        chk("R6", "str no rf write", wr_n - w0, 0);
        chk("R6", "str flags kept", cc_nzp, cc0);
        chk("R11", "str busy cycles", bcyc, 1);
    endtask

    task automatic t_st();
        run_op(pcw(4'b0011, 3'd0, 9'h100), 16'h3000, 16'h0, 16'h5A5A, 0, 0);
        chk("R3", "st addr", acc_addr[a0 % 16], 16'h2F00);
        chk("R6", "st data", mem[8'h00], 16'h5A5A);
    endtask

    task automatic t_ldi();
        mem[8'h50] = 16'h0077;
        mem[8'h77] = 16'h7FFF;
        run_op(pcw(4'b1010, 3'd7, 9'd16), 16'h0040, 16'h0, 16'h0, 0, 0);
        chk("R7", "ldi acc count", acc_n - a0, 2);
        chk("R7", "ldi ptr addr", acc_addr[a0 % 16], 16'h0050);
        chk("R7", "ldi data addr", acc_addr[(a0 + 1) % 16], 16'h0077);
        chk("R7", "ldi data", wr_data[w0 % 16], 16'h7FFF);
        chk("R11", "ldi busy cycles", bcyc, 3);
    endtask

    task automatic t_sti_wait();
        mem[8'h60] = 16'h0088;
        run_op(pcw(4'b1011, 3'd1, 9'd0), 16'h0060, 16'h0, 16'h4321, 1, 0);
        chk("R7", "sti ptr addr", acc_addr[a0 % 16], 16'h0060);
        chk("R7", "sti data addr", acc_addr[(a0 + 1) % 16], 16'h0088);
        chk("R7", "sti data", mem[8'h88], 16'h4321);
        chk("R11", "sti busy with waits", bcyc, 4);
    endtask

    task automatic t_lea();
        run_op(pcw(4'b1110, 3'd2, 9'h1FF), 16'h4000, 16'h0, 16'h0, 0, 0);
        chk("R8", "lea no access", acc_n - a0, 0);
        chk("R8", "lea value", wr_data[w0 % 16], 16'h3FFF);
        chk("R9", "lea flags P", cc_nzp, 3'b001);
        chk("R11", "lea busy cycles", bcyc, 1);
        run_op(pcw(4'b1110, 3'd2, 9'h1FE), 16'h0000, 16'h0, 16'h0, 0, 0);
        chk("R8", "lea wrap value", wr_data[w0 % 16], 16'hFFFE);
        chk("R9", "lea flags N", cc_nzp, 3'b100);
    endtask

    task automatic t_refuse();
        mem[8'hC0] = 16'h1111;
        mem[8'h50] = 16'h0077;
        run_op(pcw(4'b1010, 3'd7, 9'd16), 16'h0040, 16'h0, 16'h0, 0, 1);
        repeat (3) @(negedge clk);
        chk("R11", "refuse acc count", acc_n - a0, 2);
        chk("R11", "refuse mem kept", mem[8'hC0], 16'h1111);
        chk("R11", "refuse busy low", busy, 0);
    endtask

    task automatic t_illegal();
        logic [2:0] cc0;
        cc0 = cc_nzp;
        a0 = acc_n; w0 = wr_n;
        @(negedge clk);
        op_word = 16'h1042; op_valid = 1'b1;
        @(negedge clk);
        chk("R2", "illegal busy", busy, 0);
        op_word = 16'hC000;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2", "illegal busy 2", busy, 0);
        repeat (3) @(negedge clk);
        chk("R2", "illegal no access", acc_n - a0, 0);
        chk("R2", "illegal no rf write", wr_n - w0, 0);
        chk("R2", "illegal flags kept", cc_nzp, cc0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ld_direct();
        t_ld_wrap();
        t_ldr_wait();
        t_str();
        t_st();
        t_ldi();
        t_sti_wait();
        t_lea();
        t_refuse();
        t_illegal();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule